// File: doc/BRIEF.md
# Half-Period Resolution PWM Generator

This block produces a pulse-width-modulated square wave whose high and low phase lengths are programmed in units of half an input clock period. Its internal state moves forward on both the rising and the falling edge of a single clock, so a 100 MHz clock gives 5 ns timing steps. Phase lengths that are an odd number of half-periods, such as 5.5 clock periods, therefore come from the base clock with no faster clock and no clock synthesis.

Two register banks hold copies of the phase state. One bank updates on the rising edge and the other on the falling edge. Each bank computes its next value from the bank that changed most recently. The output takes the level bit of whichever bank is current, chosen by the clock level. A new pair of phase lengths is latched only at the edge that opens a high phase, so a period in progress always completes with the lengths it started with. The waveform period is the sum of the two phase lengths. The duty cycle in percent is 100 times the high length divided by that sum.

Top module: `dpwm_dual_edge_gen`

## Requirements
- R1: Each high phase of `pwm_o` lasts exactly `high_len` half clock periods, and both clock edges count.
- R2: Each low phase of `pwm_o` lasts exactly `low_len` half clock periods, and both clock edges count.
- R3: A programmed length of 0 acts as a length of 1, so the output never stays at one level.
- R4: Phases alternate high then low. Every period lasts the high length plus the low length, in half-periods.
- R5: `high_len` and `low_len` are sampled only at the clock edge that opens a high phase. A change made during a period first takes effect in the next period.
- R6: `rst` is synchronous and is seen on both edges. While it is asserted, `pwm_o` reads 0 after every edge, and the phase state returns to its idle value.
- R7: After `rst` is released, the first clock edge of either polarity opens a high phase.
- R8: `pwm_o` changes level only when the current phase reaches its terminal count.
- R9: The full width of the length inputs works. A length of 255 gives a phase of 255 half-periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Both edges advance the state. |
| rst | input | 1 | Synchronous reset, active high. |
| high_len | input | CNT_W | High phase length in half-periods. 0 acts as 1. |
| low_len | input | CNT_W | Low phase length in half-periods. 0 acts as 1. |
| pwm_o | output | 1 | PWM output. |

## Verification
If one edge bank holds a corrupted count or level, the fault appears at `pwm_o` within the current phase. A phase comes out one or more half-periods too long or too short, and the error grows over later periods because each bank builds on the other. A fault in the latched lengths appears one period later, when a whole high or low run differs from the length the bench captured when that period opened. A fault in the reset path appears on the first half-period after reset, either as a high level while reset is held or as a missing high level after release.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
   // number of status bits in front of the counter fields
   localparam int FLAG_W = 2;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   function automatic int state_width(input int cnt_w);
      return FLAG_W + 3 * cnt_w;
   endfunction
endpackage

// File: rtl/dpwm_step.sv
`timescale 1ns/1ps
module dpwm_step #(
   parameter int CNT_W = 8,
   localparam int ST_W = dpwm_pkg::state_width(CNT_W)
) (
   input  logic [ST_W-1:0]  cur_st,
   input  logic [CNT_W-1:0] high_in,
   input  logic [CNT_W-1:0] low_in,
   output logic [ST_W-1:0]  nxt_st
);
   import dpwm_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             c_start;
   phase_e           c_lvl;
   logic [CNT_W-1:0] c_cnt, c_hi, c_lo;
   logic             n_start;
   phase_e           n_lvl;
   logic [CNT_W-1:0] n_cnt, n_hi, n_lo;
   logic             end_low, end_high;

   assign {c_start, c_lvl, c_cnt, c_hi, c_lo} = cur_st;

   assign end_low  = (c_lvl == PH_LOW)  && (c_cnt == c_lo - ONE);
   assign end_high = (c_lvl == PH_HIGH) && (c_cnt == c_hi - ONE);

   always_comb begin
      n_start = 1'b0;
      n_lvl   = c_lvl;
      n_cnt   = c_cnt + ONE;
      n_hi    = c_hi;
      n_lo    = c_lo;
      if (c_start || end_low) begin
         n_lvl = PH_HIGH;
         n_cnt = '0;
         n_hi  = (high_in == '0) ? ONE : high_in;
         n_lo  = (low_in  == '0) ? ONE : low_in;
      end else if (end_high) begin
         n_lvl = PH_LOW;
         n_cnt = '0;
      end
   end

   assign nxt_st = {n_start, n_lvl, n_cnt, n_hi, n_lo};
endmodule

// File: rtl/dpwm_edge_reg.sv
`timescale 1ns/1ps
module dpwm_edge_reg #(
   parameter int         ST_W     = 26,
   parameter bit         RISING   = 1'b1,
   parameter logic [ST_W-1:0] IDLE_ST = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] d,
   output logic [ST_W-1:0] q
);
   generate
      if (RISING) begin : g_pos
         always_ff @(posedge clk) begin
            if (rst) q <= IDLE_ST;
            else     q <= d;
         end
      end else begin : g_neg
         always_ff @(negedge clk) begin
            if (rst) q <= IDLE_ST;
            else     q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/dpwm_merge.sv
`timescale 1ns/1ps
module dpwm_merge (
   input  logic clk,
   input  logic lvl_pos,
   input  logic lvl_neg,
   output logic lvl_out
);
   // the bank written by the most recent edge is the one whose edge matches the clock level
   assign lvl_out = clk ? lvl_pos : lvl_neg;
endmodule

// File: rtl/dpwm_dual_edge_gen.sv
`timescale 1ns/1ps
module dpwm_dual_edge_gen #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] high_len,
   input  logic [CNT_W-1:0] low_len,
   output logic             pwm_o
);
   import dpwm_pkg::*;

   localparam int ST_W = state_width(CNT_W);
   localparam logic [ST_W-1:0] IDLE_ST = {1'b1, PH_LOW, {(3*CNT_W){1'b0}}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("dpwm_dual_edge_gen: CNT_W must be at least 2");
      end
   endgenerate

   // index 0 = rising-edge bank, index 1 = falling-edge bank
   logic [ST_W-1:0] st_q [2];
   logic [ST_W-1:0] st_d [2];

   generate
      for (genvar g = 0; g < 2; g++) begin : g_bank
         dpwm_step #(.CNT_W(CNT_W)) step_i (
            .cur_st  (st_q[1-g]),
            .high_in (high_len),
            .low_in  (low_len),
            .nxt_st  (st_d[g])
         );
         dpwm_edge_reg #(.ST_W(ST_W), .RISING(g == 0), .IDLE_ST(IDLE_ST)) reg_i (
            .clk (clk),
            .rst (rst),
            .d   (st_d[g]),
            .q   (st_q[g])
         );
      end
   endgenerate

   logic             pos_start, neg_start;
   logic             pos_lvl,   neg_lvl;
   logic [CNT_W-1:0] pos_cnt, pos_hi, pos_lo;
   logic [CNT_W-1:0] neg_cnt, neg_hi, neg_lo;

   assign {pos_start, pos_lvl, pos_cnt, pos_hi, pos_lo} = st_q[0];
   assign {neg_start, neg_lvl, neg_cnt, neg_hi, neg_lo} = st_q[1];

   dpwm_merge merge_i (
      .clk     (clk),
      .lvl_pos (pos_lvl),
      .lvl_neg (neg_lvl),
      .lvl_out (pwm_o)
   );
endmodule

module dpwm_dual_edge_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             pos_start,
   input logic             pos_lvl,
   input logic [CNT_W-1:0] pos_cnt,
   input logic [CNT_W-1:0] pos_hi,
   input logic [CNT_W-1:0] pos_lo,
   input logic             neg_start,
   input logic             neg_lvl,
   input logic [CNT_W-1:0] neg_cnt,
   input logic [CNT_W-1:0] neg_hi,
   input logic [CNT_W-1:0] neg_lo
);
   // R6
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (pos_start && !pos_lvl));

   // R3
   len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      !pos_start |-> (pos_hi != '0 && pos_lo != '0));

   // R1
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      !pos_start |-> (pos_cnt < (pos_lvl ? pos_hi : pos_lo)));

   // R5
   len_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (neg_hi != pos_hi || neg_lo != pos_lo) |-> (neg_lvl && neg_cnt == '0 && !neg_start));

   // R8
   toggle_terminal_chk: assert property (@(posedge clk) disable iff (rst)
      (neg_lvl != pos_lvl) |->
         (pos_start || pos_cnt == (pos_lvl ? pos_hi : pos_lo) - CNT_W'(1)));
endmodule

bind dpwm_dual_edge_gen dpwm_dual_edge_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .pos_start (pos_start),
   .pos_lvl   (pos_lvl),
   .pos_cnt   (pos_cnt),
   .pos_hi    (pos_hi),
   .pos_lo    (pos_lo),
   .neg_start (neg_start),
   .neg_lvl   (neg_lvl),
   .neg_cnt   (neg_cnt),
   .neg_hi    (neg_hi),
   .neg_lo    (neg_lo)
);

// File: tb/dpwm_dual_edge_gen_tb_top.sv
`timescale 1ns/1ps
module dpwm_dual_edge_gen_tb_top;
   localparam int  CNT_W   = 8;
   localparam real CLK_PER = 10.0;
   localparam int  WDOG    = 150000;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [CNT_W-1:0] high_len = '0;
   logic [CNT_W-1:0] low_len  = '0;
   logic             pwm_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   dpwm_dual_edge_gen #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst(rst), .high_len(high_len), .low_len(low_len), .pwm_o(pwm_o)
   );

   always #(CLK_PER/2.0) clk = ~clk;

   // run tracking
   bit started = 0;
   bit prev    = 0;
   int run     = 0;
   int hi_cap  = 0;
   int lo_cap  = 0;
   int hi_seen = 0;

   function automatic int eff(input logic [CNT_W-1:0] v);
      return (v == '0) ? 1 : int'(v);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // wait one clock edge, sample a quarter period later, account for the run
   task automatic half_step();
      bit s;
      @(clk);
      #(CLK_PER/4.0);
      s = pwm_o;
      if (!started) begin
         if (s) begin
            started = 1;
            prev = 1;
            run = 1;
            hi_cap = eff(high_len);
            lo_cap = eff(low_len);
         end
      end else if (s == prev) begin
         run++;
      end else begin
         if (prev) begin
            hi_seen = run;
            if (hi_cap != eff(high_len))  chk(run == hi_cap, "R5 high run", run, hi_cap);
            else if (high_len == '0)      chk(run == hi_cap, "R3 high run", run, hi_cap);
            else if (hi_cap == 255)       chk(run == hi_cap, "R9 high run", run, hi_cap);
            else                          chk(run == hi_cap, "R1 high run", run, hi_cap);
         end else begin
            if (lo_cap != eff(low_len))   chk(run == lo_cap, "R5 low run", run, lo_cap);
            else if (low_len == '0)       chk(run == lo_cap, "R3 low run", run, lo_cap);
            else if (lo_cap == 255)       chk(run == lo_cap, "R9 low run", run, lo_cap);
            else                          chk(run == lo_cap, "R2 low run", run, lo_cap);
            chk(hi_seen + run == hi_cap + lo_cap, "R4 period", hi_seen + run, hi_cap + lo_cap);
            hi_cap = eff(high_len);
            lo_cap = eff(low_len);
         end
         prev = s;
         run = 1;
      end
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1;
      started = 0;
      for (int i = 0; i < n; i++) begin
         @(clk);
         #(CLK_PER/4.0);
         chk(pwm_o == 1'b0, "R6 low in reset", pwm_o, 0);
      end
      rst = 1'b0;
      @(clk);
      #(CLK_PER/4.0);
      chk(pwm_o == 1'b1, "R7 high after release", pwm_o, 1);
      started = 1;
      prev = 1;
      run = 1;
      hi_cap = eff(high_len);
      lo_cap = eff(low_len);
   endtask

   task automatic apply(input int h, input int l, input int n);
      high_len = CNT_W'(h);
      low_len  = CNT_W'(l);
      for (int i = 0; i < n; i++) half_step();
   endtask

   initial begin
      high_len = 8'd3;
      low_len  = 8'd2;
      do_reset(6);
      // sweep of small lengths including zero; hold time not aligned to periods
      for (int h = 0; h <= 6; h++)
         for (int l = 0; l <= 6; l++)
            apply(h, l, 2 * (eff(CNT_W'(h)) + eff(CNT_W'(l))) + 3);
      // cases from the timing examples: 60% of 20, odd 11, 85-long period
      apply(12, 8, 60);
      apply(11, 9, 60);
      apply(43, 42, 260);
      // change lengths inside a period (R5)
      apply(4, 4, 18);
      apply(7, 7, 2);
      apply(2, 9, 40);
      // mid-run reset (R6, R7)
      apply(5, 3, 7);
      do_reset(5);
      apply(5, 3, 30);
      // widest lengths (R9)
      apply(255, 255, 1100);
      apply(1, 1, 10);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < WDOG; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule